// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block picks one winner from a system reset request, a set of trap requests and a wide bank of peripheral interrupt requests. It hands that single vector number and its priority to the processor core. Each peripheral source has a pending flag, an enable bit and a 3-bit priority. A source is served only when its priority is strictly above the core's current priority. Reset and traps cannot be masked: they always beat interrupts and are ordered among themselves by number.

An ordinary interrupt first requests a two-cycle save of the core's context and then presents its vector. One interrupt priority level can be marked as fast. An interrupt at that level skips the context save and swaps to shadow registers instead, so it enters in one cycle. On return it produces a one-cycle restore pulse. The block also records whether a hardware repeat loop was running when an interrupt was accepted, and it signals on return that the loop should resume.

A winner stays on the vector outputs until the core acknowledges it. The acknowledge clears that one pending flag. No new arbitration happens while a vector is waiting.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, all pending flags are clear and take, ctx_save, shadow_save, exit_fast and loop_resume are low.
- R2: A pulse on src_req[i] sets a pending flag. If source i is enabled and its priority is above cpu_prio, it is presented with vector 8 + (i mod 8) and take_prio equal to {1'b0, priority of source i}.
- R3: Among qualified interrupt sources, the highest priority wins, and a tie goes to the lower source index.
- R4: A source whose priority is less than or equal to cpu_prio, or whose enable bit is low, is not taken. It stays pending and is served once it qualifies.
- R5: Exceptions outrank every interrupt, regardless of enables or cpu_prio. The reset request uses vector 0 with priority 15. Trap k (1..7, on trap_req[k-1]) uses vector k with priority 15-k. A lower exception number wins. Exceptions are presented one cycle after the pending flag is set, with no ctx_save.
- R6: For a non-fast interrupt, ctx_save is high for exactly the two cycles after the decision, and take rises in the cycle that follows.
- R7: When fast_en is high and the winner's priority equals fast_lvl, take rises one cycle after the decision, with shadow_save high and no ctx_save.
- R8: While take is high, the vector and priority hold until ack. An ack clears only the served source's pending flag. An ack while take is low has no effect.
- R9: An rfi after a fast interrupt produces exit_fast high for exactly one cycle, in the next cycle. After a non-fast interrupt, rfi produces no exit_fast.
- R10: If rpt_active is high in the ack cycle, the next rfi produces loop_resume high for one cycle. Otherwise loop_resume stays low.
- R11: A request that arrives while a vector waits for ack does not replace that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 32 | Interrupt request per source, sets pending |
| src_en | input | 32 | Enable per source |
| src_prio | input | 96 | 3-bit priority per source, source i at bits [3i+2:3i] |
| rst_vec_req | input | 1 | Reset vector request |
| trap_req | input | 7 | Trap requests, trap k on bit k-1 |
| cpu_prio | input | 3 | Current core priority |
| fast_en | input | 1 | Enables the fast level |
| fast_lvl | input | 3 | Priority level served as fast |
| rpt_active | input | 1 | Hardware repeat loop running |
| ack | input | 1 | Core accepts the presented vector |
| rfi | input | 1 | Core returns from interrupt |
| take | output | 1 | Vector presented |
| take_vec | output | 4 | Vector number |
| take_prio | output | 4 | Priority of the presented vector |
| ctx_save | output | 1 | Context save request (non-fast interrupt) |
| shadow_save | output | 1 | Shadow register swap on fast entry |
| exit_fast | output | 1 | Shadow restore pulse on fast return |
| loop_resume | output | 1 | Repeat loop resume pulse on return |

## Verification
A request pulse is seen by the arbiter one edge after it is driven. An exception or fast interrupt then raises take after one more edge. A non-fast interrupt shows ctx_save after one and two more edges and take after the third. exit_fast and loop_resume appear one edge after rfi, and take falls one edge after ack. The bench drives and samples only on falling edges and steps exactly these counts. It checks ctx_save, shadow_save and take at each intermediate cycle, so a save sequence that is one cycle too short or too long is caught.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    IVC_IDLE,
    IVC_SAVE_A,
    IVC_SAVE_B,
    IVC_ISSUE
  } ivc_state_e;

  // Interrupt vectors follow the exception vectors: base + (source mod count)
  function automatic int unsigned int_vector(input int unsigned src,
                                             input int unsigned nivec,
                                             input int unsigned nexc);
    return nexc + (src % nivec);
  endfunction

  // Exceptions sit above every interrupt level: top code minus the number
  function automatic int unsigned exc_level(input int unsigned k,
                                            input int unsigned pw);
    return (32'd1 << (pw + 1)) - 32'd1 - k;
  endfunction

endpackage

// File: rtl/ivc_pending.sv
module ivc_pending #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | set;
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((pend & $past(clr & ~set)) == '0)); // R8

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NEXC  = 8,
  parameter int NIVEC = 8,
  parameter int PW    = 3,
  parameter int VW    = 4,
  parameter int IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_pend,
  input  logic [NSRC-1:0]  src_en,
  input  logic [NSRC*PW-1:0] src_prio,
  input  logic [NEXC-1:0]  exc_pend,
  input  logic [PW-1:0]    cpu_prio,
  input  logic             fast_en,
  input  logic [PW-1:0]    fast_lvl,
  output logic             win_valid,
  output logic             win_exc,
  output logic             win_fast,
  output logic [VW-1:0]    win_vec,
  output logic [PW:0]      win_prio,
  output logic [IW-1:0]    win_idx
);

  localparam int LW = PW + 1;

  logic          int_hit;
  logic [PW-1:0] best_p;
  logic [IW-1:0] best_i;
  logic          exc_hit;
  logic [IW-1:0] exc_i;
  logic [PW-1:0] cur_p;

  // Interrupt search: strict compare keeps the lower index on a tie
  always_comb begin
    int_hit = 1'b0;
    best_p  = '0;
    best_i  = '0;
    cur_p   = '0;
    for (int i = 0; i < NSRC; i++) begin
      cur_p = src_prio[i*PW +: PW];
      if (src_pend[i] && src_en[i] && (cur_p > cpu_prio) &&
          (!int_hit || (cur_p > best_p))) begin
        int_hit = 1'b1;
        best_p  = cur_p;
        best_i  = IW'(i);
      end
    end
  end

  // Exception search: lowest number wins
  always_comb begin
    exc_hit = 1'b0;
    exc_i   = '0;
    for (int k = NEXC - 1; k >= 0; k--) begin
      if (exc_pend[k]) begin
        exc_hit = 1'b1;
        exc_i   = IW'(k);
      end
    end
  end

  always_comb begin
    win_valid = exc_hit | int_hit;
    win_exc   = exc_hit;
    win_fast  = !exc_hit && int_hit && fast_en && (best_p == fast_lvl);
    win_idx   = exc_hit ? exc_i : best_i;
    win_vec   = exc_hit ? VW'(exc_i)
                        : VW'(int_vector(32'(best_i), NIVEC, NEXC));
    win_prio  = exc_hit ? LW'(exc_level(32'(exc_i), PW)) : {1'b0, best_p};
  end

  AST_INT_ABOVE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_exc) |-> (win_prio > {1'b0, cpu_prio})); // R4

  AST_EXC_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|exc_pend) |-> (win_exc && !win_fast)); // R5

endmodule

// File: rtl/ivc_sequencer.sv
module ivc_sequencer
  import ivc_pkg::*;
#(
  parameter int PW = 3,
  parameter int VW = 4,
  parameter int IW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  logic          win_exc,
  input  logic          win_fast,
  input  logic [VW-1:0] win_vec,
  input  logic [PW:0]   win_prio,
  input  logic [IW-1:0] win_idx,
  input  logic          ack,
  input  logic          rfi,
  input  logic          rpt_active,
  output logic          take,
  output logic [VW-1:0] take_vec,
  output logic [PW:0]   take_prio,
  output logic          take_exc,
  output logic [IW-1:0] take_idx,
  output logic          accept,
  output logic          ctx_save,
  output logic          shadow_save,
  output logic          exit_fast,
  output logic          loop_resume
);

  ivc_state_e state;
  logic       l_fast;
  logic       fast_act;
  logic       rpt_saved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= IVC_IDLE;
      l_fast      <= 1'b0;
      take_exc    <= 1'b0;
      take_vec    <= '0;
      take_prio   <= '0;
      take_idx    <= '0;
      fast_act    <= 1'b0;
      rpt_saved   <= 1'b0;
      exit_fast   <= 1'b0;
      loop_resume <= 1'b0;
    end else begin
      exit_fast   <= rfi & fast_act;
      loop_resume <= rfi & rpt_saved;
      if (rfi) begin
        fast_act  <= 1'b0;
        rpt_saved <= 1'b0;
      end
      case (state)
        IVC_IDLE: if (win_valid) begin
          l_fast    <= win_fast;
          take_exc  <= win_exc;
          take_vec  <= win_vec;
          take_prio <= win_prio;
          take_idx  <= win_idx;
          state     <= (win_exc || win_fast) ? IVC_ISSUE : IVC_SAVE_A;
        end
        IVC_SAVE_A: state <= IVC_SAVE_B;
        IVC_SAVE_B: state <= IVC_ISSUE;
        IVC_ISSUE: if (ack) begin
          state     <= IVC_IDLE;
          fast_act  <= l_fast;
          rpt_saved <= rpt_active;
        end
        default: state <= IVC_IDLE;
      endcase
    end
  end

  assign take        = (state == IVC_ISSUE);
  assign ctx_save    = (state == IVC_SAVE_A) || (state == IVC_SAVE_B);
  assign shadow_save = take & l_fast;
  assign accept      = take & ack;

  AST_TAKE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !ack) |=> (take && $stable(take_vec) && $stable(take_prio))); // R8

  AST_SAVE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctx_save) |=> ctx_save ##1 (!ctx_save && take)); // R6

  AST_FAST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(take) && shadow_save) |-> !$past(ctx_save)); // R7

  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_fast |=> !exit_fast); // R9

  AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    loop_resume |=> !loop_resume); // R10

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int NSRC  = 32,
  parameter int NTRAP = 7,
  parameter int NIVEC = 8,
  parameter int PW    = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      src_req,
  input  logic [NSRC-1:0]      src_en,
  input  logic [NSRC*PW-1:0]   src_prio,
  input  logic                 rst_vec_req,
  input  logic [NTRAP-1:0]     trap_req,
  input  logic [PW-1:0]        cpu_prio,
  input  logic                 fast_en,
  input  logic [PW-1:0]        fast_lvl,
  input  logic                 rpt_active,
  input  logic                 ack,
  input  logic                 rfi,
  output logic                 take,
  output logic [$clog2(NTRAP+1+NIVEC)-1:0] take_vec,
  output logic [PW:0]          take_prio,
  output logic                 ctx_save,
  output logic                 shadow_save,
  output logic                 exit_fast,
  output logic                 loop_resume
);

  localparam int NEXC = NTRAP + 1;
  localparam int VW   = $clog2(NEXC + NIVEC);
  localparam int IW   = $clog2((NSRC > NEXC) ? NSRC : NEXC);

  logic [NSRC-1:0] src_pend;
  logic [NEXC-1:0] exc_pend;
  logic [NSRC-1:0] src_clr;
  logic [NEXC-1:0] exc_clr;
  logic            win_valid, win_exc, win_fast;
  logic [VW-1:0]   win_vec;
  logic [PW:0]     win_prio;
  logic [IW-1:0]   win_idx;
  logic            take_exc, accept;
  logic [IW-1:0]   take_idx;

  assign src_clr = (accept && !take_exc) ? (NSRC'(1) << take_idx) : '0;
  assign exc_clr = (accept &&  take_exc) ? (NEXC'(1) << take_idx) : '0;

  ivc_pending #(.W(NSRC)) u_src_pend (
    .clk(clk), .rst_n(rst_n), .set(src_req), .clr(src_clr), .pend(src_pend)
  );

  ivc_pending #(.W(NEXC)) u_exc_pend (
    .clk(clk), .rst_n(rst_n), .set({trap_req, rst_vec_req}), .clr(exc_clr),
    .pend(exc_pend)
  );

  ivc_arbiter #(
    .NSRC(NSRC), .NEXC(NEXC), .NIVEC(NIVEC), .PW(PW), .VW(VW), .IW(IW)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .src_pend(src_pend), .src_en(src_en), .src_prio(src_prio),
    .exc_pend(exc_pend), .cpu_prio(cpu_prio),
    .fast_en(fast_en), .fast_lvl(fast_lvl),
    .win_valid(win_valid), .win_exc(win_exc), .win_fast(win_fast),
    .win_vec(win_vec), .win_prio(win_prio), .win_idx(win_idx)
  );

  ivc_sequencer #(.PW(PW), .VW(VW), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .win_valid(win_valid), .win_exc(win_exc), .win_fast(win_fast),
    .win_vec(win_vec), .win_prio(win_prio), .win_idx(win_idx),
    .ack(ack), .rfi(rfi), .rpt_active(rpt_active),
    .take(take), .take_vec(take_vec), .take_prio(take_prio),
    .take_exc(take_exc), .take_idx(take_idx), .accept(accept),
    .ctx_save(ctx_save), .shadow_save(shadow_save),
    .exit_fast(exit_fast), .loop_resume(loop_resume)
  );

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({src_clr, exc_clr}) <= 1); // R8

endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_req = '0;
  logic [31:0] src_en = '0;
  logic [95:0] src_prio = '0;
  logic        rst_vec_req = 1'b0;
  logic [6:0]  trap_req = '0;
  logic [2:0]  cpu_prio = '0;
  logic        fast_en = 1'b0;
  logic [2:0]  fast_lvl = '0;
  logic        rpt_active = 1'b0;
  logic        ack = 1'b0;
  logic        rfi = 1'b0;
  logic        take;
  logic [3:0]  take_vec;
  logic [3:0]  take_prio;
  logic        ctx_save, shadow_save, exit_fast, loop_resume;

  int nrun = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
    .src_prio(src_prio), .rst_vec_req(rst_vec_req), .trap_req(trap_req),
    .cpu_prio(cpu_prio), .fast_en(fast_en), .fast_lvl(fast_lvl),
    .rpt_active(rpt_active), .ack(ack), .rfi(rfi), .take(take),
    .take_vec(take_vec), .take_prio(take_prio), .ctx_save(ctx_save),
    .shadow_save(shadow_save), .exit_fast(exit_fast),
    .loop_resume(loop_resume)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(input int i, input int p, input bit en);
    src_prio[i*3 +: 3] = p[2:0];
    src_en[i] = en;
  endtask

  task automatic pulse(input logic [31:0] m, input logic [6:0] t, input logic r);
    src_req = m; trap_req = t; rst_vec_req = r;
    step(1);
    src_req = '0; trap_req = '0; rst_vec_req = 1'b0;
  endtask

  // mode 0: context save path, 1: fast path, 2: exception path
  task automatic wait_take(input int vec, input int prio, input int mode, input string tag);
    if (mode == 0) begin
      step(1);
      chk({tag, " R6 ctx_save cycle1"}, ctx_save, 1);
      chk({tag, " R6 take low cycle1"}, take, 0);
      step(1);
      chk({tag, " R6 ctx_save cycle2"}, ctx_save, 1);
      step(1);
      chk({tag, " R6 ctx_save ends"}, ctx_save, 0);
      chk({tag, " R6 take"}, take, 1);
      chk({tag, " R7 no shadow"}, shadow_save, 0);
    end else begin
      step(1);
      chk({tag, " R7 take one cycle"}, take, 1);
      chk({tag, " R7 no ctx_save"}, ctx_save, 0);
      chk({tag, " R7 shadow_save"}, shadow_save, (mode == 1) ? 1 : 0);
    end
    chk({tag, " vector"}, take_vec, vec);
    chk({tag, " priority"}, take_prio, prio);
  endtask

  task automatic do_ack;
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R8 take drops after ack", take, 0);
  endtask

  task automatic serve(input int vec, input int prio, input int mode, input string tag);
    wait_take(vec, prio, mode, tag);
    do_ack();
  endtask

  task automatic t_reset;
    chk("R1 take", take, 0);
    chk("R1 ctx_save", ctx_save, 0);
    chk("R1 shadow_save", shadow_save, 0);
    chk("R1 exit_fast", exit_fast, 0);
    chk("R1 loop_resume", loop_resume, 0);
    step(3);
    chk("R1 idle with no request", take | ctx_save, 0);
  endtask

  task automatic t_basic;
    cfg(10, 3, 1'b1);
    pulse(32'h1 << 10, '0, 1'b0);
    serve(10, 3, 0, "R2 src10");
  endtask

  task automatic t_tie;
    cfg(20, 6, 1'b1); cfg(3, 5, 1'b1); cfg(9, 5, 1'b1);
    pulse((32'h1 << 20) | (32'h1 << 3) | (32'h1 << 9), '0, 1'b0);
    serve(12, 6, 0, "R3 highest first");
    serve(11, 5, 0, "R3 tie lower index");
    serve(9, 5, 0, "R3 last");
  endtask

  task automatic t_mask;
    cpu_prio = 3'd4;
    cfg(5, 4, 1'b1); cfg(6, 7, 1'b0);
    pulse((32'h1 << 5) | (32'h1 << 6), '0, 1'b0);
    step(4);
    chk("R4 masked not taken", take, 0);
    chk("R4 masked no save", ctx_save, 0);
    ack = 1'b1; step(1); ack = 1'b0;       // stray ack, R8
    src_en[6] = 1'b1;
    serve(14, 7, 0, "R4 enabled later");
    cpu_prio = 3'd3;
    serve(13, 4, 0, "R4 R8 kept pending");
    cpu_prio = 3'd0;
  endtask

  task automatic t_exc;
    cfg(1, 7, 1'b1);
    pulse(32'h1 << 1, 7'b0010100, 1'b0);
    serve(3, 12, 2, "R5 trap3");
    serve(5, 10, 2, "R5 trap5");
    serve(9, 7, 0, "R5 interrupt after traps");
    pulse('0, 7'b0000010, 1'b1);
    serve(0, 15, 2, "R5 reset vector");
    serve(2, 13, 2, "R5 trap2");
    cpu_prio = 3'd7;
    pulse('0, 7'b1000000, 1'b0);
    serve(7, 8, 2, "R5 trap7 ignores cpu_prio");
    cpu_prio = 3'd0;
  endtask

  task automatic t_fast;
    fast_en = 1'b1; fast_lvl = 3'd6;
    cfg(7, 6, 1'b1);
    pulse(32'h1 << 7, '0, 1'b0);
    wait_take(15, 6, 1, "R7 fast");
    rpt_active = 1'b1;
    do_ack();
    rpt_active = 1'b0;
    rfi = 1'b1; step(1); rfi = 1'b0;
    chk("R9 exit_fast pulse", exit_fast, 1);
    chk("R10 loop_resume pulse", loop_resume, 1);
    step(1);
    chk("R9 exit_fast one cycle", exit_fast, 0);
    chk("R10 loop_resume one cycle", loop_resume, 0);
    cfg(2, 2, 1'b1);
    pulse(32'h1 << 2, '0, 1'b0);
    serve(10, 2, 0, "R9 non-fast");
    rfi = 1'b1; step(1); rfi = 1'b0;
    chk("R9 no exit_fast after non-fast", exit_fast, 0);
    chk("R10 no loop_resume", loop_resume, 0);
    fast_en = 1'b0;
  endtask

  task automatic t_hold;
    cfg(17, 1, 1'b1); cfg(18, 7, 1'b1);
    pulse(32'h1 << 17, '0, 1'b0);
    wait_take(9, 1, 0, "R11 first");
    pulse(32'h1 << 18, '0, 1'b0);
    step(2);
    chk("R11 take held", take, 1);
    chk("R11 vector held", take_vec, 9);
    chk("R11 priority held", take_prio, 1);
    do_ack();
    serve(10, 7, 0, "R11 late arrival");
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_basic();
    t_tie();
    t_mask();
    t_exc();
    t_fast();
    t_hold();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nrun++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

endmodule